// File: doc/BRIEF.md
# Tick-Sampled Up/Down Event Counter Pair

This block keeps two 16-bit event counters fed from one shared 8-bit input port. The port is looked at only when the periodic `tick` input is high. Each counter owns three fixed bits of the port: a count clock, a direction and a synchronous clear. A count happens only when the count-clock bit is high in the current sample and was low in the sample taken at the previous tick. A host write port can load either counter with a 16-bit value at any time. Both counter values are always visible on one flat read-back output.

Each counter lane settles on one action per clock cycle, chosen by priority. `ACT_LOAD` is taken when the host writes to this lane. `ACT_CLEAR` is taken on a tick whose clear bit is high. `ACT_UP` or `ACT_DOWN` is taken on a tick that shows a rising clock edge, with the direction bit choosing between them. `ACT_HOLD` covers every other cycle. Every action moves the lane back to its count register, so there is no multi-cycle sequence. The action chosen in a cycle determines the register value after the next clock edge. Separately from the action, the lane's stored clock snapshot is refreshed on every tick, whatever action is taken.

Top module: `evc_counter_pair`

## Requirements
- R1: While `rst_n` is low, and after it rises, both counters read 0 and both stored clock snapshots are low.
- R2: Counter 0 uses port bit 0 as its count clock, bit 1 as its direction and bit 2 as its clear. Counter 1 uses bits 4, 5 and 6 for the same roles. Counter i appears on `cnt_out[16*i+15:16*i]`.
- R3: On a tick where a counter's clear bit is high, that counter becomes 0 and does not count on that tick.
- R4: A counter changes by one only on a tick where its clock bit is high and the snapshot from the previous tick is low. Port changes between ticks have no effect.
- R5: On a counting tick, the counter goes up by one when its direction bit is 1 and down by one when it is 0.
- R6: Counting wraps in both directions: 0xFFFF goes to 0x0000 going up, and 0x0000 goes to 0xFFFF going down.
- R7: The clock snapshot is refreshed on every tick, including clear ticks. A clock bit that stays high across a clear tick and the following tick gives no count.
- R8: A host write with `wr_en` high loads `wr_data` into the counter picked by `wr_sel`, with `wr_data[7:0]` as the low byte. The other counter is not changed.
- R9: A host write wins over a clear or a count on the same cycle. The tick still refreshes the snapshot of the written lane.
- R10: Every change becomes visible on `cnt_out` one clock edge after the cycle that causes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample strobe; the port is examined only when this is high |
| port_in | input | 8 | Shared event port (clock, direction and clear bits) |
| wr_en | input | 1 | Host load strobe |
| wr_sel | input | 1 | Index of the counter to load |
| wr_data | input | 16 | Load value, low byte in [7:0] |
| cnt_out | output | 32 | Counter values, counter i in bits [16*i+15:16*i] |

## Verification
The assertions assume that `tick`, `port_in` and the write inputs are stable around each clock edge and free of X once reset has been released. They also assume that `wr_sel` only ever names an existing counter, which a 1-bit select guarantees with two lanes. The stimulus changes inputs only on the falling clock edge and draws every value from fixed-width $urandom slices, so each value is a legal encoding. Host writes are kept rare in the random phase so that runs of edges, clears and wraps have time to build up between loads.

// File: rtl/evc_pkg.sv
package evc_pkg;
    localparam int CNT_W    = 16;
    localparam int PORT_W   = 8;
    localparam int NUM_CTR  = 2;
    localparam int SEL_W    = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
    localparam int LANE_STRIDE = 4;
    localparam int OFS_CLK  = 0;
    localparam int OFS_DIR  = 1;
    localparam int OFS_CLR  = 2;

    typedef enum logic [2:0] {
        ACT_HOLD  = 3'd0,
        ACT_CLEAR = 3'd1,
        ACT_UP    = 3'd2,
        ACT_DOWN  = 3'd3,
        ACT_LOAD  = 3'd4
    } evc_act_e;

    function automatic int lane_bit(input int lane, input int ofs);
        return lane * LANE_STRIDE + ofs;
    endfunction
endpackage

// File: rtl/evc_action.sv
module evc_action
    import evc_pkg::*;
(
    input  logic     ld,
    input  logic     tick,
    input  logic     clk_now,
    input  logic     clk_prev,
    input  logic     dir_now,
    input  logic     clr_now,
    output evc_act_e act
);
    logic edge_seen;

    always_comb begin
        edge_seen = clk_now & ~clk_prev;
        act = ACT_HOLD;
        if (ld) begin
            act = ACT_LOAD;
        end else if (tick) begin
            if (clr_now)
                act = ACT_CLEAR;
            else if (edge_seen)
                act = dir_now ? ACT_UP : ACT_DOWN;
        end
    end
endmodule

// File: rtl/evc_lane.sv
module evc_lane
    import evc_pkg::*;
#(
    parameter int W      = 16,
    parameter int PW     = 8,
    parameter int CLK_B  = 0,
    parameter int DIR_B  = 1,
    parameter int CLR_B  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [PW-1:0] port_in,
    input  logic          ld,
    input  logic [W-1:0]  ld_val,
    output logic [W-1:0]  value
);
    localparam logic [W-1:0] ONE = W'(1);

    evc_act_e     act;
    logic         prev_q;
    logic [W-1:0] value_q;
    logic [W-1:0] value_d;

    evc_action u_act (
        .ld       (ld),
        .tick     (tick),
        .clk_now  (port_in[CLK_B]),
        .clk_prev (prev_q),
        .dir_now  (port_in[DIR_B]),
        .clr_now  (port_in[CLR_B]),
        .act      (act)
    );

    // count register: next value chosen per action
    always_comb begin
        value_d = value_q;
        unique case (act)
            ACT_HOLD:  value_d = value_q;
            ACT_CLEAR: value_d = '0;
            ACT_UP:    value_d = value_q + ONE;
            ACT_DOWN:  value_d = value_q - ONE;
            ACT_LOAD:  value_d = ld_val;
            default:   value_d = value_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            value_q <= '0;
        else
            value_q <= value_d;
    end

    // snapshot of the clock bit, refreshed on every tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else if (tick)
            prev_q <= port_in[CLK_B];
    end

    assign value = value_q;
endmodule

// File: rtl/evc_counter_pair.sv
module evc_counter_pair
    import evc_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PORT_W,
    parameter int NC = NUM_CTR,
    parameter int SW = SEL_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [PW-1:0]  port_in,
    input  logic           wr_en,
    input  logic [SW-1:0]  wr_sel,
    input  logic [CW-1:0]  wr_data,
    output logic [NC*CW-1:0] cnt_out
);
    for (genvar i = 0; i < NC; i++) begin : g_lane
        logic          ld_i;
        logic [CW-1:0] val_i;

        assign ld_i = wr_en && (wr_sel == SW'(i));

        evc_lane #(
            .W     (CW),
            .PW    (PW),
            .CLK_B (lane_bit(i, OFS_CLK)),
            .DIR_B (lane_bit(i, OFS_DIR)),
            .CLR_B (lane_bit(i, OFS_CLR))
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .port_in (port_in),
            .ld      (ld_i),
            .ld_val  (wr_data),
            .value   (val_i)
        );

        assign cnt_out[i*CW +: CW] = val_i;
    end
endmodule

// File: rtl/evc_pair_chk.sv
module evc_pair_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic [7:0]  port_in,
    input logic        wr_en,
    input logic        wr_sel,
    input logic [15:0] wr_data,
    input logic [31:0] cnt_out
);
    logic [15:0] c0, c1;
    logic        ld0, ld1;
    logic        sp0, sp1;

    assign c0  = cnt_out[15:0];
    assign c1  = cnt_out[31:16];
    assign ld0 = wr_en && !wr_sel;
    assign ld1 = wr_en && wr_sel;

    // checker-owned snapshots of the clock bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp0 <= 1'b0;
            sp1 <= 1'b0;
        end else if (tick) begin
            sp0 <= port_in[0];
            sp1 <= port_in[4];
        end
    end

    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> cnt_out == 32'h0);

    a_r3_clear0: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld0 && port_in[2]) |=> c0 == 16'h0);

    a_r3_clear1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld1 && port_in[6]) |=> c1 == 16'h0);

    a_r4_hold0: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld0 && (!tick || (!port_in[2] && !(port_in[0] && !sp0)))) |=> $stable(c0));

    a_r5_up0: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld0 && !port_in[2] && port_in[0] && !sp0 && port_in[1])
        |=> c0 == 16'($past(c0) + 16'd1));

    a_r5_down1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld1 && !port_in[6] && port_in[4] && !sp1 && !port_in[5])
        |=> c1 == 16'($past(c1) - 16'd1));

    a_r8_load0: assert property (@(posedge clk) disable iff (!rst_n)
        ld0 |=> c0 == $past(wr_data));

    a_r8_load1_keeps0: assert property (@(posedge clk) disable iff (!rst_n)
        (ld1 && !tick) |=> (c1 == $past(wr_data)) && $stable(c0));
endmodule

bind evc_counter_pair evc_pair_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .port_in (port_in),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .cnt_out (cnt_out)
);

// File: tb/evc_counter_pair_test.sv
module evc_counter_pair_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  port_in = 8'h0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic [31:0] cnt_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0] m_cnt [2];
    logic        m_prev [2];

    always #5 clk = ~clk;

    evc_counter_pair uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .port_in(port_in),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .cnt_out(cnt_out)
    );

    // expected next value of counter i from the requirement rules
    function automatic logic [15:0] exp_next(input int i, input logic [15:0] cur,
            input logic prv, input logic tk, input logic [7:0] p,
            input logic we, input logic sel, input logic [15:0] d);
        int b = 4 * i;                                   // R2 bit layout
        if (we && (sel == i[0])) return d;               // R8, R9
        if (tk && p[b+2]) return 16'h0;                  // R3
        if (tk && p[b] && !prv)                          // R4
            return p[b+1] ? cur + 16'd1 : cur - 16'd1;   // R5, R6
        return cur;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic tk, input logic [7:0] p, input logic we,
                        input logic sel, input logic [15:0] d, input string req);
        tick = tk; port_in = p; wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk);
        for (int i = 0; i < 2; i++) begin
            m_cnt[i] = exp_next(i, m_cnt[i], m_prev[i], tk, p, we, sel, d);
            if (tk) m_prev[i] = p[4*i];                  // R7
        end
        @(negedge clk);                                   // R10
        tick = 1'b0; wr_en = 1'b0;
        check(req, cnt_out[15:0], m_cnt[0]);
        check(req, cnt_out[31:16], m_cnt[1]);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 2; i++) begin m_cnt[i] = 16'h0; m_prev[i] = 1'b0; end
        rst_n = 1'b0;
        // reset with port activity applied: R1
        port_in = 8'hFF; wr_en = 1'b1; wr_data = 16'h1234;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", cnt_out[15:0], 16'h0);
        check("R1", cnt_out[31:16], 16'h0);
        rst_n = 1'b1; wr_en = 1'b0; port_in = 8'h00;
        @(negedge clk);
        check("R1", cnt_out[31:0] == 32'h0 ? 16'h0 : 16'h1, 16'h0);

        // R2 R5: counter 0 up on bit 0 edge with bit 1 high
        step(1, 8'h03, 0, 0, 0, "R5");
        check("R2", cnt_out[15:0], 16'h0001);
        check("R2", cnt_out[31:16], 16'h0000);
        // R4: clock still high, no new edge
        step(1, 8'h03, 0, 0, 0, "R4");
        check("R4", cnt_out[15:0], 16'h0001);
        // R4: port toggles without tick
        step(0, 8'h00, 0, 0, 0, "R4");
        step(0, 8'h33, 0, 0, 0, "R4");
        check("R4", cnt_out[15:0], 16'h0001);
        step(1, 8'h00, 0, 0, 0, "R4");
        // R2 R5: counter 1 down on bit 4 edge with bit 5 low
        step(1, 8'h10, 0, 0, 0, "R5");
        check("R6", cnt_out[31:16], 16'hFFFF);
        // R6: wrap up on counter 1
        step(1, 8'h20, 0, 0, 0, "R6");
        step(1, 8'h30, 0, 0, 0, "R6");
        check("R6", cnt_out[31:16], 16'h0000);
        // R8: load counter 0 with 0xFFFF then count up to wrap
        step(0, 8'h00, 1, 0, 16'hFFFF, "R8");
        check("R8", cnt_out[15:0], 16'hFFFF);
        check("R8", cnt_out[31:16], 16'h0000);
        step(1, 8'h02, 0, 0, 0, "R6");
        step(1, 8'h03, 0, 0, 0, "R6");
        check("R6", cnt_out[15:0], 16'h0000);
        // R3 R7: clear with clock high, then clock stays high
        step(1, 8'h00, 0, 0, 0, "R7");
        step(0, 8'h00, 1, 0, 16'h00A5, "R8");
        step(1, 8'h07, 0, 0, 0, "R3");
        check("R3", cnt_out[15:0], 16'h0000);
        step(1, 8'h03, 0, 0, 0, "R7");
        check("R7", cnt_out[15:0], 16'h0000);
        // R9: write on the same cycle as a counting tick on counter 1
        step(1, 8'h00, 0, 0, 0, "R9");
        step(1, 8'h30, 1, 1, 16'h5A5A, "R9");
        check("R9", cnt_out[31:16], 16'h5A5A);
        step(1, 8'h30, 0, 0, 0, "R9");
        check("R9", cnt_out[31:16], 16'h5A5A);
        // R9: write beats clear
        step(1, 8'h44, 1, 1, 16'h0F0F, "R9");
        check("R9", cnt_out[31:16], 16'h0F0F);

        // random phase
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] r = 8'($urandom);
            logic [7:0] p = 8'($urandom);
            logic [7:0] q = 8'($urandom);
            // make clears rarer than counts
            if (q[2:0] != 3'd0) p[2] = 1'b0;
            if (q[5:3] != 3'd0) p[6] = 1'b0;
            step(r[1:0] != 2'b00, p, r[7:4] == 4'hF, r[2], 16'($urandom), "R4 R5 R8");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule